// File: doc/BRIEF.md
# Paged Shift-Register Program Counter

This block holds the fetch address of a small 4-bit controller core. The address is split into an in-page step field (the low 7 bits) and page-select bits above it. A normal advance does not count in binary: the step field moves through a linear feedback shift register sequence, and the page bits never change. Because of this, code runs around a 128-step page unless a branch leaves it.

The surrounding core decodes each instruction and tells the block what to do through `op_sel`, together with the opcode byte and the second (parameter) byte of two-byte instructions. The block supports five operations. It can advance, jump inside the current page, jump to a long target, call a long target (pushing a return address onto a 4-entry circular stack), and return. A synchronous reset and a wake-up request force fixed vectors. The only output is the registered fetch address.

Top module: `lfsr_paged_pc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_addr` becomes 0x000 and the return stack becomes empty with its last-pushed value cleared to 0x000. Reset overrides every other input, including `wake_req`.
- R2: With `step` high and `op_sel` = 0 (advance), the next address keeps bits 8:7. Bits 5:0 take the old bits 6:1, and bit 6 becomes 1 when old bits 0 and 1 are equal and 0 when they differ.
- R3: With `step` low and `wake_req` low, `pc_addr` holds its value whatever `op_sel`, `op_code` and `op_param` carry, and the stack is not touched.
- R4: With `step` high and `op_sel` = 1 (page jump), an opcode with bit 7 set keeps the page bits and loads bits 6:0 from opcode bits 6:0. An opcode with bit 7 clear is treated as a plain advance.
- R5: With `step` high and `op_sel` = 2 (long jump), the target has bit 9 = opcode bit 1, bit 8 = opcode bit 0, bit 7 = parameter bit 7 and bits 6:0 = parameter bits 6:0. It is then cut to the 9-bit address width.
- R6: With `step` high and `op_sel` = 3 (long call), the address is loaded as in R5. The address reached by two advances from the call's own address is pushed onto the return stack.
- R7: With `step` high and `op_sel` = 4 (return), the most recently pushed entry still on the stack is loaded into `pc_addr` and removed from the stack.
- R8: The return stack holds 4 entries. A push onto a full stack discards the oldest entry.
- R9: A return with an empty stack loads the last value ever pushed (0x000 if none since reset) and leaves the stack empty.
- R10: With `rst_n` high, `wake_req` high forces `pc_addr` to 0x080 (page bits 01, step 0) whether or not `step` is high, and takes priority over any `op_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the reset vector |
| step | input | 1 | Advance strobe: the address updates only when high (except wake) |
| op_sel | input | 3 | Operation: 0 advance, 1 page jump, 2 long jump, 3 long call, 4 return |
| op_code | input | 8 | First instruction byte |
| op_param | input | 8 | Second instruction byte of long jumps and calls |
| wake_req | input | 1 | Forces the wake-up vector |
| pc_addr | output | 9 | Current fetch address |

## Verification
The hardest states to reach from the ports are the stack edge cases: a fifth push overwriting the oldest entry, and a return on an empty stack. Both depend on a history of calls made from chosen addresses. The stimulus first places the counter at five known in-page addresses with page jumps. It calls from each one, then returns five times. The expected return addresses are worked out by applying the shift-register rule twice to each call address. The vector table also walks the shift sequence across page-jump, long-jump and call boundaries, so a wrong feedback bit or a wrong field position shows up as a wrong address.

// File: rtl/lfsr_pc_pkg.sv
// Shared definitions for the paged program counter.
// Assumes an 8-bit opcode stream and a step field of PAGE_W bits.
package lfsr_pc_pkg;
    localparam int PAGE_W  = 7;   // in-page step field width
    localparam int TGT_W   = 10;  // full width of an assembled branch target
    localparam int OP_W    = 8;   // opcode and parameter byte width
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        PC_ADVANCE = 3'd0,
        PC_JPAGE   = 3'd1,
        PC_JLONG   = 3'd2,
        PC_CALL    = 3'd3,
        PC_RETURN  = 3'd4
    } pc_op_e;

    localparam logic [TGT_W-1:0] WAKE_VEC  = 10'h080;
    localparam logic [TGT_W-1:0] RESET_VEC = 10'h000;
endpackage

// File: rtl/pc_lfsr_step.sv
// One advance of the in-page shift register.
// Assumes ADDR_W >= PAGE_W; page bits pass through untouched.
module pc_lfsr_step #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic feed;

    // Feedback bit: 1 when the two lowest bits agree.
    always_comb feed = ~(cur_addr[0] ^ cur_addr[1]);

    generate
        if (ADDR_W > PAGE_W) begin : g_paged
            assign nxt_addr = {cur_addr[ADDR_W-1:PAGE_W], feed, cur_addr[PAGE_W-1:1]};
        end else begin : g_flat
            assign nxt_addr = {feed, cur_addr[PAGE_W-1:1]};
        end
    endgenerate
endmodule

// File: rtl/pc_target_build.sv
// Assembles a long-branch target from scattered opcode and parameter bits:
// bit 9 = opcode bit 1, bit 8 = opcode bit 0, bits 7:0 = parameter byte.
// Assumes 9 <= ADDR_W; bits above TGT_W are zero, excess bits are cut.
module pc_target_build
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        op_lo,
    input  logic [OP_W-1:0]   param,
    output logic [ADDR_W-1:0] target
);
    logic [TGT_W-1:0] full_tgt;

    // Field placement of the page and step parts.
    always_comb full_tgt = {op_lo[1], op_lo[0], param[7], param[6:0]};

    generate
        if (ADDR_W >= TGT_W) begin : g_wide
            assign target = {{(ADDR_W-TGT_W){1'b0}}, full_tgt};
        end else begin : g_cut
            assign target = full_tgt[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pc_return_stack.sv
// Circular return-address stack. A push onto a full stack overwrites
// the oldest entry; a pop on an empty stack yields the last value pushed.
// Assumes push and pop are never requested together.
module pc_return_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] pop_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] up_idx;
    logic [PTR_W-1:0] down_idx;
    logic [CNT_W-1:0] fill;
    logic [W-1:0]     last_pushed;

    // Wrapping neighbour indices of the top slot.
    always_comb begin
        up_idx   = (top_idx == LAST_IDX) ? '0 : top_idx + 1'b1;
        down_idx = (top_idx == '0) ? LAST_IDX : top_idx - 1'b1;
    end

    // Value offered to a return.
    always_comb pop_data = (fill != '0) ? slots[top_idx] : last_pushed;

    // Pointer, fill level and last-push register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_idx     <= LAST_IDX;
            fill        <= '0;
            last_pushed <= '0;
        end else if (push) begin
            top_idx     <= up_idx;
            last_pushed <= push_data;
            if (fill != FULL_CNT) fill <= fill + 1'b1;
        end else if (pop && fill != '0) begin
            top_idx <= down_idx;
            fill    <= fill - 1'b1;
        end
    end

    // Storage slots, one write port.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slots[i] <= '0;
                else if (push && up_idx == PTR_W'(i))
                    slots[i] <= push_data;
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_paged_pc.sv
// Program counter with a shift-register in-page step, page jumps, long
// jumps, long calls with a circular return stack, returns, and reset and
// wake vectors. Priority: reset, wake, then the selected operation when
// step is high. Assumes op_sel is decoded by the core.
module lfsr_paged_pc
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int STACK_LVL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic [OP_W-1:0]   op_code,
    input  logic [OP_W-1:0]   op_param,
    input  logic              wake_req,
    output logic [ADDR_W-1:0] pc_addr
);
    localparam logic [ADDR_W-1:0] WAKE_A  = WAKE_VEC[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] RESET_A = RESET_VEC[ADDR_W-1:0];

    pc_op_e            sel;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] adv_one;
    logic [ADDR_W-1:0] adv_two;
    logic [ADDR_W-1:0] long_tgt;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] pc_d;
    logic              do_push;
    logic              do_pop;

    // Decode the select into the package enum.
    always_comb sel = pc_op_e'(op_sel);

    pc_lfsr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step1 (
        .cur_addr (pc_q),
        .nxt_addr (adv_one)
    );

    pc_lfsr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step2 (
        .cur_addr (adv_one),
        .nxt_addr (adv_two)
    );

    pc_target_build #(.ADDR_W(ADDR_W)) u_tgt (
        .op_lo  (op_code[1:0]),
        .param  (op_param),
        .target (long_tgt)
    );

    // Stack requests, only for a stepped cycle without wake.
    always_comb begin
        do_push = step && !wake_req && (sel == PC_CALL);
        do_pop  = step && !wake_req && (sel == PC_RETURN);
    end

    pc_return_stack #(.DEPTH(STACK_LVL), .W(ADDR_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (adv_two),
        .pop_data  (ret_addr)
    );

    // Next-address selection by priority.
    always_comb begin
        pc_d = pc_q;
        if (wake_req) begin
            pc_d = WAKE_A;
        end else if (step) begin
            unique case (sel)
                PC_JPAGE:  pc_d = op_code[7]
                                ? {pc_q[ADDR_W-1:PAGE_W], op_code[PAGE_W-1:0]}
                                : adv_one;
                PC_JLONG,
                PC_CALL:   pc_d = long_tgt;
                PC_RETURN: pc_d = ret_addr;
                default:   pc_d = adv_one;
            endcase
        end
    end

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_A;
        else        pc_q <= pc_d;
    end

    assign pc_addr = pc_q;
endmodule

// File: rtl/lfsr_paged_pc_checker.sv
// Temporal checks on the program counter ports; attached by bind.
module lfsr_paged_pc_checker
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [SEL_W-1:0]  op_sel,
    input logic [OP_W-1:0]   op_code,
    input logic [OP_W-1:0]   op_param,
    input logic              wake_req,
    input logic [ADDR_W-1:0] pc_addr
);
    logic [TGT_W-1:0] exp_long;

    // Reference long target from the raw bytes.
    always_comb exp_long = {op_code[1:0], op_param};

    // R3: no step, no wake: address holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wake_req) |=> $stable(pc_addr));

    // R2: advance shifts the step field and keeps the page.
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wake_req && op_sel == 3'd0) |=>
        (pc_addr[ADDR_W-1:PAGE_W] == $past(pc_addr[ADDR_W-1:PAGE_W]) &&
         pc_addr[PAGE_W-2:0] == $past(pc_addr[PAGE_W-1:1])));

    // R4: page jump with opcode bit 7 set.
    a_r4_page_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wake_req && op_sel == 3'd1 && op_code[7]) |=>
        (pc_addr[PAGE_W-1:0] == $past(op_code[PAGE_W-1:0]) &&
         pc_addr[ADDR_W-1:PAGE_W] == $past(pc_addr[ADDR_W-1:PAGE_W])));

    // R5 and R6: long jump and call land on the assembled target.
    a_r5_long_target: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wake_req && (op_sel == 3'd2 || op_sel == 3'd3)) |=>
        (pc_addr == $past(exp_long[ADDR_W-1:0])));

    // R10: wake forces the wake vector.
    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> (pc_addr == WAKE_VEC[ADDR_W-1:0]));
endmodule

bind lfsr_paged_pc lfsr_paged_pc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .op_sel   (op_sel),
    .op_code  (op_code),
    .op_param (op_param),
    .wake_req (wake_req),
    .pc_addr  (pc_addr)
);

// File: tb/lfsr_paged_pc_test.sv
// Self-checking bench: vector table walk, then directed stack and reset tests.
module lfsr_paged_pc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] op_param = 8'h00;
    logic       wake_req = 1'b0;
    logic [8:0] pc_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lfsr_paged_pc uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .op_sel   (op_sel),
        .op_code  (op_code),
        .op_param (op_param),
        .wake_req (wake_req),
        .pc_addr  (pc_addr)
    );

    // Vector fields: req(4) sel(3) op(8) param(8) step(1) wake(1) expect(9)
    localparam int NV = 19;
    localparam logic [33:0] VEC [NV] = '{
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h040},  // R2
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h060},  // R2
        {4'd3,  3'd1, 8'h95, 8'h00, 1'b0, 1'b0, 9'h060},  // R3 ignored
        {4'd4,  3'd1, 8'h95, 8'h00, 1'b1, 1'b0, 9'h015},  // R4
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h00A},  // R2
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h005},  // R2
        {4'd4,  3'd1, 8'h33, 8'h00, 1'b1, 1'b0, 9'h002},  // R4 bit7 clear
        {4'd5,  3'd2, 8'h79, 8'hA3, 1'b1, 1'b0, 9'h1A3},  // R5
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h1D1},  // R2
        {4'd6,  3'd3, 8'h7E, 8'h05, 1'b1, 1'b0, 9'h005},  // R6 bit9 cut
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h002},  // R2
        {4'd6,  3'd3, 8'h7C, 8'h80, 1'b1, 1'b0, 9'h080},  // R6
        {4'd7,  3'd4, 8'h00, 8'h00, 1'b1, 1'b0, 9'h000},  // R7
        {4'd7,  3'd4, 8'h00, 8'h00, 1'b1, 1'b0, 9'h1D4},  // R7
        {4'd9,  3'd4, 8'h00, 8'h00, 1'b1, 1'b0, 9'h000},  // R9
        {4'd10, 3'd0, 8'h00, 8'h00, 1'b1, 1'b1, 9'h080},  // R10
        {4'd3,  3'd1, 8'hFF, 8'h00, 1'b0, 1'b0, 9'h080},  // R3
        {4'd4,  3'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 9'h0FF},  // R4
        {4'd2,  3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h0FF}   // R2 fixed point
    };

    // Bench model of one advance.
    function automatic logic [8:0] adv(input logic [8:0] p);
        return {p[8:7], ~(p[0] ^ p[1]), p[6:1]};
    endfunction

    task automatic check(input int req, input logic [8:0] exp_v);
        n_checks++;
        if (pc_addr !== exp_v) begin
            n_fail++;
            $display("FAIL R%0d: pc_addr=%h expected %h", req, pc_addr, exp_v);
        end
    endtask

    // Drive at a falling edge; the result is sampled one cycle later.
    task automatic apply(input logic [2:0] s, input logic [7:0] o,
                         input logic [7:0] p, input logic st, input logic wk);
        @(negedge clk);
        op_sel = s; op_code = o; op_param = p; step = st; wake_req = wk;
        @(negedge clk);
        step = 1'b0; wake_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [8:0] rets [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, 9'h000);   // R1 reset state

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][29:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10], VEC[i][9]);
            check(int'(VEC[i][33:30]), VEC[i][8:0]);
        end

        // R1: reset with wake and a call pending, then empty-stack return gives 0.
        @(negedge clk);
        rst_n = 1'b0; wake_req = 1'b1; step = 1'b1; op_sel = 3'd3; op_param = 8'h55;
        @(negedge clk);
        check(1, 9'h000);
        rst_n = 1'b1; wake_req = 1'b0; step = 1'b0;
        apply(3'd4, 8'h00, 8'h00, 1'b1, 1'b0);
        check(1, 9'h000);   // R1 stack cleared, R9 empty pop

        // R10: wake without step, with a return selected.
        apply(3'd4, 8'h00, 8'h00, 1'b0, 1'b1);
        check(10, 9'h080);
        apply(3'd2, 8'h00, 8'h00, 1'b1, 1'b0);   // back to page 0, address 0
        check(5, 9'h000);

        // R8: five calls from known addresses, then five returns.
        for (int k = 0; k < 5; k++) begin
            apply(3'd1, 8'h90 + 8'(k), 8'h00, 1'b1, 1'b0);
            check(4, 9'h010 + 9'(k));
            rets[k] = adv(adv(9'h010 + 9'(k)));
            apply(3'd3, 8'h7C, 8'h00, 1'b1, 1'b0);
            check(6, 9'h000);
        end
        for (int k = 4; k >= 1; k--) begin
            apply(3'd4, 8'h00, 8'h00, 1'b1, 1'b0);
            check(8, rets[k]);   // R8 oldest (k=0) was discarded
        end
        apply(3'd4, 8'h00, 8'h00, 1'b1, 1'b0);
        check(9, rets[4]);       // R9 empty returns last pushed

        finish_run();
    end
endmodule